// File: doc/BRIEF.md
# Clocked Serial Byte Interface with Prescaled Clock

This block moves one byte at a time over a synchronous three-wire serial link: a serial clock, a data output and a data input. A host sets up the link through a byte-wide control register. That register holds the clock polarity, the data phase and a three-bit clock-source code. When the code picks an internal source, the block is the clock master. It makes the serial clock from the system clock by a power-of-two division and drives it onto the clock pin. When the code is all ones, the block is a slave. It takes the serial clock from the pin, passes it through a synchronizer and follows its edges.

The host starts a transfer by writing the byte to send on the data side of the register port. This write is the start strobe. The block then shifts that byte out, most significant bit first, while it shifts the partner's byte in. After eight serial clock periods it raises the complete flag. The received byte is then read on the same data side of the port. The control register is frozen for the whole transfer, so the clock rate and the timing type cannot change part way through a byte.

Top module: `serial_xfer`

## Requirements
- R1: After reset the control register reads 0x00, `busy` and `done` are low, `sclk_oe` is high and `sclk_o` is low.
- R2: A write with `reg_sel`=0 updates only the control bits whose `reg_wmask` bit is 1. Bit 4 is the clock polarity, bit 3 is the data phase and bits 2:0 are the clock-select code. Bits 7:5 always read 0. A read with `reg_sel`=0 returns the control register.
- R3: For select codes 0 to 6 the block is master (`sclk_oe`=1). Each half period of `sclk_o` lasts 2^code system cycles, so a full period is the system clock divided by 2^(code+1). The first edge comes exactly 2^code cycles after the cycle of the start write, and a transfer is 16 edges long.
- R4: Select code 7 makes the block a slave. `sclk_oe` is 0, and shifting and sampling follow the edges of `sclk_i`, with the first edge leaving the polarity level.
- R5: In master mode, whenever no transfer is running, `sclk_o` equals the polarity bit.
- R6: With phase 0, `sdo` shows bit 7 from the cycle after the start write. Each leading edge (edges 1, 3, …, 15 counted from 1) samples `sdi`. Each trailing edge except the last drives the next bit. Outside a transfer `sdo` holds its value.
- R7: With phase 1, each leading edge drives the next bit on `sdo`, starting with bit 7, and each trailing edge samples `sdi`.
- R8: Both directions run most significant bit first. After completion, a read with `reg_sel`=1 returns the received byte.
- R9: `done` rises and `busy` falls in the cycle after the 16th edge. In master mode that is 16·2^code cycles after the start write. A start write clears `done` and raises `busy` in the next cycle.
- R10: Control writes made while `busy` is high have no effect.
- R11: Data writes made while `busy` is high neither restart nor alter the running transfer.
- R12: In slave mode `sclk_i` passes through a two-stage synchronizer, and edges are detected on the synchronized level. A byte clocked in from an asynchronous external clock is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| reg_wdata | input | 8 | Write data |
| reg_wmask | input | 8 | Per-bit write enable for control writes |
| reg_rdata | output | 8 | Read data for the side chosen by `reg_sel` |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | High when the block drives the serial clock |
| sclk_i | input | 1 | External serial clock used in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| done | output | 1 | Transfer-complete flag |
| busy | output | 1 | Transfer in progress |

## Verification
The assertions check the cycle-level rules on every cycle. These are: the reserved control bits read zero, the master clock rests at the polarity level while idle, a start clears the flag and raises `busy`, the flag rises only as `busy` falls, the control register stays stable during a transfer, and `sdo` stays quiet outside a transfer. Other behaviours are visible only through the bench's scenarios. These cover the exact division ratio per code, the first edge arriving after a full half period, the bit order, the edge on which each timing type drives and samples, the discarded data writes mid-byte, and correct reception from an asynchronous external clock. For those, a behavioural model that counts cycles since the start is compared with the pins.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

    localparam int CKS_W    = 3;
    localparam logic [CKS_W-1:0] CKS_EXT = '1;
    localparam int MAX_HALF = 1 << ((1 << CKS_W) - 2);
    localparam int PCNT_W   = $clog2(MAX_HALF);

    typedef struct packed {
        logic [2:0]       rsv;
        logic             pol;
        logic             pha;
        logic [CKS_W-1:0] cks;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } sel_e;

    function automatic logic is_ext(input ctrl_t c);
        return c.cks == CKS_EXT;
    endfunction

    // last prescaler count of one half period for a given select code
    function automatic logic [PCNT_W-1:0] half_last(input logic [CKS_W-1:0] cks);
        return PCNT_W'((1 << cks) - 1);
    endfunction

endpackage

// File: rtl/sxu_ctrl_reg.sv
module sxu_ctrl_reg
    import sxu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  logic  lock,
    input  ctrl_t wdata,
    input  ctrl_t wmask,
    output ctrl_t ctrl
);

    ctrl_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr && !lock) begin
            q <= ctrl_t'((q & ~wmask) | (wdata & wmask));
        end
    end

    always_comb begin
        ctrl     = q;
        ctrl.rsv = '0;
    end

endmodule

// File: rtl/sxu_clkgen.sv
module sxu_clkgen
    import sxu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  busy,
    input  logic  start,
    input  logic  sclk_in,
    output logic  edge_stb
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [PCNT_W-1:0]      pcnt;
    logic [SYNC_STAGES-1:0] sync;
    logic                   sync_prev;
    logic                   int_edge;
    logic                   ext_edge;

    assign int_edge = (pcnt == half_last(ctrl.cks));
    assign ext_edge = sync[LAST] ^ sync_prev;

    // prescaler restarts with every transfer so the first half period is full
    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (start || !busy || int_edge) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync[g] <= 1'b0;
                else     sync[g] <= sclk_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync[g] <= 1'b0;
                else     sync[g] <= sync[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_prev <= 1'b0;
        else     sync_prev <= sync[LAST];
    end

    assign edge_stb = busy && (is_ext(ctrl) ? ext_edge : int_edge);

endmodule

// File: rtl/sxu_shifter.sv
module sxu_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              pha,
    input  logic              edge_stb,
    input  logic              sdi,
    output logic              busy,
    output logic              phase,
    output logic              sdo,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);

    localparam int EDGES = 2 * DATA_W;
    localparam int EC_W  = $clog2(EDGES);

    logic [EC_W-1:0]   ecnt;
    logic [DATA_W-1:0] txs;
    logic [DATA_W-1:0] rxs;
    logic              lead;
    logic              last;
    logic              drive_now;
    logic              samp_now;
    logic [DATA_W-1:0] rx_next;

    assign lead      = !ecnt[0];
    assign last      = (ecnt == EC_W'(EDGES - 1));
    assign drive_now = pha ? lead : (!lead && !last);
    assign samp_now  = pha ? !lead : lead;
    assign rx_next   = samp_now ? {rxs[DATA_W-2:0], sdi} : rxs;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            phase   <= 1'b0;
            sdo     <= 1'b0;
            ecnt    <= '0;
            txs     <= '0;
            rxs     <= '0;
            rx_data <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            phase <= 1'b0;
            ecnt  <= '0;
            rxs   <= '0;
            if (!pha) begin
                sdo <= tx_data[DATA_W-1];
                txs <= {tx_data[DATA_W-2:0], 1'b0};
            end else begin
                txs <= tx_data;
            end
        end else if (busy && edge_stb) begin
            phase <= ~phase;
            ecnt  <= ecnt + 1'b1;
            rxs   <= rx_next;
            if (drive_now) begin
                sdo <= txs[DATA_W-1];
                txs <= {txs[DATA_W-2:0], 1'b0};
            end
            if (last) begin
                busy    <= 1'b0;
                done    <= 1'b1;
                rx_data <= rx_next;
            end
        end
    end

endmodule

// File: rtl/serial_xfer.sv
module serial_xfer
    import sxu_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_wmask,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sclk_i,
    output logic              sdo,
    input  logic              sdi,
    output logic              done,
    output logic              busy
);

    ctrl_t             ctrl_w;
    logic              ctrl_wr;
    logic              start_w;
    logic              edge_w;
    logic              phase_w;
    logic [DATA_W-1:0] rx_w;

    assign ctrl_wr = reg_wr && (sel_e'(reg_sel) == SEL_CTRL);
    assign start_w = reg_wr && (sel_e'(reg_sel) == SEL_DATA) && !busy;

    sxu_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctrl_wr),
        .lock  (busy),
        .wdata (ctrl_t'(reg_wdata[CTRL_W-1:0])),
        .wmask (ctrl_t'(reg_wmask[CTRL_W-1:0])),
        .ctrl  (ctrl_w)
    );

    sxu_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_w),
        .busy     (busy),
        .start    (start_w),
        .sclk_in  (sclk_i),
        .edge_stb (edge_w)
    );

    sxu_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start_w),
        .tx_data  (reg_wdata),
        .pha      (ctrl_w.pha),
        .edge_stb (edge_w),
        .sdi      (sdi),
        .busy     (busy),
        .phase    (phase_w),
        .sdo      (sdo),
        .done     (done),
        .rx_data  (rx_w)
    );

    assign sclk_o    = ctrl_w.pol ^ phase_w;
    assign sclk_oe   = !is_ext(ctrl_w);
    assign reg_rdata = (sel_e'(reg_sel) == SEL_CTRL) ? DATA_W'(ctrl_w) : rx_w;

endmodule

// File: rtl/sxu_chk.sv
module sxu_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              start,
    input logic              sdo,
    input logic              sclk_o,
    input logic              sclk_oe,
    input logic [7:0]        ctrl,
    input logic              reg_sel,
    input logic [DATA_W-1:0] reg_rdata
);

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 1'b0) |-> (reg_rdata[7:5] == 3'b000));

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && sclk_oe) |-> (sclk_o == ctrl[4]));

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !done));

    // R9
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!busy && $past(busy)));

    // R10
    ctrl_lock_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctrl));

    // R6
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(sdo));

endmodule

bind serial_xfer sxu_chk #(.DATA_W(DATA_W)) u_sxu_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .start     (start_w),
    .sdo       (sdo),
    .sclk_o    (sclk_o),
    .sclk_oe   (sclk_oe),
    .ctrl      (8'(ctrl_w)),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata)
);

// File: tb/test_serial_xfer.sv
module test_serial_xfer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_wmask = '0;
    logic [7:0] reg_rdata;
    logic       sclk_o, sclk_oe, sdo, done, busy;
    logic       sclk_i = 1'b0;
    logic       sdi;

    always #4 clk = ~clk;

    serial_xfer i_serial_xfer (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i), .sdo(sdo),
        .sdi(sdi), .done(done), .busy(busy)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural reference state
    bit         m_on = 0, m_done = 0, m_ext = 0, last_ext = 0;
    int         m_j = 0, m_half = 1;
    logic [7:0] m_tx = '0, m_pat = '0, exp_ctrl = '0;
    logic       m_pol = 0, m_pha = 0, slv_sdi = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int min7(input int v);
        return (v > 7) ? 7 : v;
    endfunction

    always @(posedge clk) begin
        bit was_on;
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (rst) begin
            m_on = 0; m_done = 0; exp_ctrl = '0;
        end else begin
            was_on = m_on;
            if (m_on) begin
                m_j++;
                if (!m_ext && m_j == 16 * m_half) begin m_on = 0; m_done = 1; end
                if (m_ext && done) begin m_on = 0; m_done = 1; end
            end
            if (reg_wr && !reg_sel && !was_on)
                exp_ctrl = ((exp_ctrl & ~reg_wmask) | (reg_wdata & reg_wmask)) & 8'h1F;
            if (reg_wr && reg_sel && !was_on) begin
                m_on = 1; m_j = 0; m_done = 0;
                m_tx = reg_wdata; m_pol = exp_ctrl[4]; m_pha = exp_ctrl[3];
                m_ext = (exp_ctrl[2:0] == 3'b111); last_ext = m_ext;
                m_half = 1 << exp_ctrl[2:0];
            end
        end
    end

    // per-cycle comparison and master-side partner drive, away from the active edge
    always @(negedge clk) begin
        int  e, idx;
        bit  cur_ext;
        logic nsdi;
        nsdi = 1'b0;
        if (!rst) begin
            cur_ext = m_on ? m_ext : (exp_ctrl[2:0] == 3'b111);
            chk(cur_ext ? "R4 sclk_oe" : "R3 sclk_oe", sclk_oe, !cur_ext);
            if (m_on && !m_ext) begin
                e = m_j / m_half;
                chk("R9 busy", busy, 1);
                chk("R9 done", done, 0);
                chk("R3 sclk_o", sclk_o, m_pol ^ e[0]);
                if (!m_pha) begin
                    idx = min7(e / 2);
                    chk("R6 sdo", sdo, m_tx[7-idx]);
                    nsdi = m_pat[7-idx];
                end else if (e > 0) begin
                    idx = min7((e + 1) / 2 - 1);
                    chk("R7 sdo", sdo, m_tx[7-idx]);
                    nsdi = m_pat[7-idx];
                end
            end else if (!m_on) begin
                chk("R9 busy idle", busy, 0);
                chk("R9 done idle", done, m_done);
                if (!cur_ext) chk("R5 idle sclk", sclk_o, exp_ctrl[4]);
                if (m_done && !last_ext) chk("R6 sdo hold", sdo, m_tx[0]);
            end
        end
        sdi = (m_on && m_ext) ? slv_sdi : nsdi;
    end

    task automatic wr_ctrl(input logic [7:0] v, input logic [7:0] mk);
        @(negedge clk);
        reg_wr = 1; reg_sel = 0; reg_wdata = v; reg_wmask = mk;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1; reg_sel = 1; reg_wdata = v; reg_wmask = '0;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input logic s, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_sel = s;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && m_on; k++) @(negedge clk);
    endtask

    task automatic master_run(input logic [7:0] c, input logic [7:0] tx, input logic [7:0] pat);
        wr_ctrl(c, 8'hFF);
        m_pat = pat;
        wr_data(tx);
        wait_idle();
        rd_chk(1'b1, pat, "R8 rx byte");
    endtask

    task automatic slave_run(input logic pol, input logic pha, input logic [7:0] tx, input logic [7:0] pat);
        logic [7:0] cap;
        cap = '0;
        sclk_i = pol;
        wr_ctrl({3'b000, pol, pha, 3'b111}, 8'hFF);
        repeat (6) @(negedge clk);
        wr_data(tx);
        for (int k = 0; k < 8; k++) begin
            if (!pha) begin
                slv_sdi = pat[7-k];
                repeat (8) @(negedge clk);
                cap = {cap[6:0], sdo};
                sclk_i = !pol;
                repeat (8) @(negedge clk);
                sclk_i = pol;
            end else begin
                repeat (8) @(negedge clk);
                sclk_i = !pol;
                slv_sdi = pat[7-k];
                repeat (8) @(negedge clk);
                cap = {cap[6:0], sdo};
                sclk_i = pol;
            end
        end
        repeat (6) @(negedge clk);
        chk("R12 slave done", done, 1);
        chk("R4 slave tx order", cap, tx);
        rd_chk(1'b1, pat, "R12 slave rx");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd_chk(1'b0, 8'h00, "R1 ctrl reset");
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 sclk_o", sclk_o, 0);
        chk("R1 sclk_oe", sclk_oe, 1);

        // R2 masked writes, reserved bits
        wr_ctrl(8'hE5, 8'hFF);
        rd_chk(1'b0, 8'h05, "R2 reserved zero");
        wr_ctrl(8'h10, 8'h10);
        rd_chk(1'b0, 8'h15, "R2 single bit");
        wr_ctrl(8'h00, 8'h07);
        rd_chk(1'b0, 8'h10, "R2 field mask");

        // master transfers across timing types and ratios (R3, R5, R6, R7, R8, R9)
        master_run(8'h00, 8'hA5, 8'h3C);
        master_run(8'h11, 8'h81, 8'hC3);
        master_run(8'h0A, 8'h5A, 8'h96);
        master_run(8'h18, 8'hF0, 8'h0F);
        master_run(8'h06, 8'h01, 8'h80);
        master_run(8'h1B, 8'h7E, 8'hE7);

        // back-to-back start right after completion clears done (R9)
        m_pat = 8'h55;
        wr_data(8'hAA);
        wait_idle();
        rd_chk(1'b1, 8'h55, "R9 back to back rx");

        // writes during a transfer are dropped (R10, R11)
        wr_ctrl(8'h0A, 8'hFF);
        m_pat = 8'h69;
        wr_data(8'hC6);
        repeat (5) @(negedge clk);
        wr_ctrl(8'h17, 8'hFF);
        wr_data(8'h12);
        wait_idle();
        rd_chk(1'b0, 8'h0A, "R10 ctrl kept");
        rd_chk(1'b1, 8'h69, "R11 rx intact");

        // external clock (R4, R12)
        slave_run(1'b0, 1'b0, 8'hB4, 8'h2D);
        slave_run(1'b1, 1'b1, 8'h47, 8'hE2);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule